// File: doc/BRIEF.md
# Memory ECC Error Injection Controller

This block sits on the write path of one memory channel. It corrupts outgoing ECC check bits on purpose, and it can also flip the address parity, so that error handling further down the path can be tested. Software sets it up through a small register port. The port holds an address-match value, an address-match mask, a 32-bit flip mask for the check bits, and a control word.

Every outgoing write beat presents its address, a flag that says which half of the cacheline it carries, and its 32-bit ECC codeword. One cycle later the block returns the codeword, possibly altered, together with a strobe that tells the parity generator to invert the address parity.

An injection is armed by writing the control word. By default it fires on one matching beat and then disarms itself. With repeat mode on, it corrupts every matching beat until software clears it. ECC injection and parity injection share a single address match.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, all four registers read 0 and `out_valid` and `out_par_flip` are low.
- R2: Register select 0 is the match address, 1 the match mask, 2 the ECC flip mask and 3 the control word. In the control word, bit 0 is repeat, bits 2:1 are the half select, bit 3 is the ECC arm and bit 4 is the parity arm. Bits 31:5 read 0 whatever is written to them.
- R3: A beat matches when `(addr & match_mask) == (match_addr & match_mask)`. A zero match mask lets every beat match.
- R4: Each input beat appears one cycle later with `out_valid` high. If the ECC arm did not fire on that beat, `out_ecc` equals the input codeword. If it fired, `out_ecc` is the input XOR the flip mask.
- R5: The half select, with `xfer_upper` = 1 marking the upper 32-byte half, works as follows. 00 and 11 allow either half. 01 allows only the lower half. 10 allows only the upper half.
- R6: In one-shot mode, the ECC arm bit reads 0 after the first corrupted beat, and later beats pass through unchanged.
- R7: The parity arm makes `out_par_flip` high alongside the output of a matching beat. It disarms itself under the same one-shot rule as the ECC arm.
- R8: With repeat set, every matching beat is corrupted and the arm bits stay set until software writes them to 0.
- R9: The ECC arm and the parity arm each work alone or together. When both fire on the same beat, both clear on the same edge.
- R10: A control-word write in the same cycle as a self-clear takes effect, and the self-clear is dropped.
- R11: A beat that does not match, or that falls in a half that is not selected, does not use up a one-shot arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select for writes |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 2 | Register select for reads |
| reg_rd_data | output | 32 | Read data (combinational) |
| xfer_valid | input | 1 | Write beat present |
| xfer_addr | input | ADDR_W | Beat address |
| xfer_upper | input | 1 | 1 = upper half of the cacheline |
| xfer_ecc | input | ECC_W | ECC codeword in |
| out_valid | output | 1 | Registered beat valid |
| out_ecc | output | ECC_W | Codeword out, possibly corrupted |
| out_par_flip | output | 1 | Invert address parity for this beat |

## Verification
The hardest case to reach is a control-word write that lands in the same cycle as a one-shot self-clear. The ordinary write task cannot create it, because it always spaces a write away from the beats. The bench therefore raises the write strobe and the beat valid together on one falling edge. It then expects the next matching beat to be corrupted as well, and the beat after that to pass through clean. A second subtle case is a non-matching beat sent while a one-shot arm is active. The bench sends such beats first, then reads the control word and sends a matching beat to show that the arm is still in place.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        SEL_MADDR = 2'd0,
        SEL_MMASK = 2'd1,
        SEL_EMASK = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        HALF_ANY  = 2'd0,
        HALF_LOW  = 2'd1,
        HALF_HIGH = 2'd2,
        HALF_BOTH = 2'd3
    } half_sel_e;

    // packed MSB first: par_arm is bit 4, repeat_en is bit 0
    typedef struct packed {
        logic      par_arm;
        logic      ecc_arm;
        half_sel_e half;
        logic      repeat_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic half_allowed(half_sel_e sel, logic upper);
        case (sel)
            HALF_LOW:  return !upper;
            HALF_HIGH: return upper;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/inj_regs.sv
module inj_regs
    import ecc_inj_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ECC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_sel,
    output logic [REG_W-1:0]  rd_data,
    input  logic              clr_ecc,
    input  logic              clr_par,
    output logic [ADDR_W-1:0] match_addr,
    output logic [ADDR_W-1:0] match_mask,
    output logic [ECC_W-1:0]  flip_mask,
    output ctrl_t             ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_addr <= '0;
            match_mask <= '0;
            flip_mask  <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_MADDR: match_addr <= wr_data[ADDR_W-1:0];
                SEL_MMASK: match_mask <= wr_data[ADDR_W-1:0];
                SEL_EMASK: flip_mask  <= wr_data[ECC_W-1:0];
                default: ;
            endcase
        end
    end

    // software write outranks the hardware self-clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && reg_sel_e'(wr_sel) == SEL_CTRL) begin
            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end else begin
            if (clr_ecc) ctrl.ecc_arm <= 1'b0;
            if (clr_par) ctrl.par_arm <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            SEL_MADDR: rd_data[ADDR_W-1:0] = match_addr;
            SEL_MMASK: rd_data[ADDR_W-1:0] = match_mask;
            SEL_EMASK: rd_data[ECC_W-1:0]  = flip_mask;
            default:   rd_data[CTRL_W-1:0] = ctrl;
        endcase
    end

endmodule

// File: rtl/inj_match.sv
module inj_match
    import ecc_inj_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              upper,
    input  logic [ADDR_W-1:0] match_addr,
    input  logic [ADDR_W-1:0] match_mask,
    input  half_sel_e         half,
    output logic              hit
);

    logic addr_eq;

    assign addr_eq = ((addr ^ match_addr) & match_mask) == '0;
    assign hit     = valid && addr_eq && half_allowed(half, upper);

endmodule

// File: rtl/inj_apply.sv
module inj_apply
    import ecc_inj_pkg::*;
#(
    parameter int ECC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [ECC_W-1:0] ecc_in,
    input  logic             hit,
    input  ctrl_t            ctrl,
    input  logic [ECC_W-1:0] flip_mask,
    output logic             ecc_fire,
    output logic             par_fire,
    output logic             clr_ecc,
    output logic             clr_par,
    output logic             out_valid,
    output logic [ECC_W-1:0] out_ecc,
    output logic             out_par_flip
);

    assign ecc_fire = hit && ctrl.ecc_arm;
    assign par_fire = hit && ctrl.par_arm;
    assign clr_ecc  = ecc_fire && !ctrl.repeat_en;
    assign clr_par  = par_fire && !ctrl.repeat_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_ecc      <= '0;
            out_par_flip <= 1'b0;
        end else begin
            out_valid    <= valid;
            out_ecc      <= ecc_fire ? (ecc_in ^ flip_mask) : ecc_in;
            out_par_flip <= par_fire;
        end
    end

endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
    import ecc_inj_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ECC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [31:0]       reg_wr_data,
    input  logic [1:0]        reg_rd_sel,
    output logic [31:0]       reg_rd_data,
    input  logic              xfer_valid,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic              xfer_upper,
    input  logic [ECC_W-1:0]  xfer_ecc,
    output logic              out_valid,
    output logic [ECC_W-1:0]  out_ecc,
    output logic              out_par_flip
);

    logic [ADDR_W-1:0] match_addr;
    logic [ADDR_W-1:0] match_mask;
    logic [ECC_W-1:0]  flip_mask;
    ctrl_t             ctrl_q;
    logic              hit;
    logic              ecc_fire;
    logic              par_fire;
    logic              clr_ecc;
    logic              clr_par;

    inj_regs #(.ADDR_W(ADDR_W), .ECC_W(ECC_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .wr_data   (reg_wr_data),
        .rd_sel    (reg_rd_sel),
        .rd_data   (reg_rd_data),
        .clr_ecc   (clr_ecc),
        .clr_par   (clr_par),
        .match_addr(match_addr),
        .match_mask(match_mask),
        .flip_mask (flip_mask),
        .ctrl      (ctrl_q)
    );

    inj_match #(.ADDR_W(ADDR_W)) u_match (
        .valid     (xfer_valid),
        .addr      (xfer_addr),
        .upper     (xfer_upper),
        .match_addr(match_addr),
        .match_mask(match_mask),
        .half      (ctrl_q.half),
        .hit       (hit)
    );

    inj_apply #(.ECC_W(ECC_W)) u_apply (
        .clk         (clk),
        .rst         (rst),
        .valid       (xfer_valid),
        .ecc_in      (xfer_ecc),
        .hit         (hit),
        .ctrl        (ctrl_q),
        .flip_mask   (flip_mask),
        .ecc_fire    (ecc_fire),
        .par_fire    (par_fire),
        .clr_ecc     (clr_ecc),
        .clr_par     (clr_par),
        .out_valid   (out_valid),
        .out_ecc     (out_ecc),
        .out_par_flip(out_par_flip)
    );

endmodule

// File: rtl/ecc_inject_chk.sv
module ecc_inject_chk #(
    parameter int ECC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [1:0]       reg_wr_sel,
    input logic [31:0]      reg_wr_data,
    input logic [1:0]       reg_rd_sel,
    input logic [31:0]      reg_rd_data,
    input logic             xfer_valid,
    input logic [ECC_W-1:0] xfer_ecc,
    input logic             out_valid,
    input logic [ECC_W-1:0] out_ecc,
    input logic             out_par_flip,
    input logic             ecc_fire,
    input logic             par_fire,
    input logic             ctl_rep,
    input logic             ctl_ecc,
    input logic             ctl_par,
    input logic [4:0]       ctl_all
);

    logic ctrl_wr;
    assign ctrl_wr = reg_wr_en && reg_wr_sel == 2'd3;

    AST_RESV_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rd_sel == 2'd3 |-> reg_rd_data[31:5] == '0); // R2

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && !ctl_ecc |=> out_valid && out_ecc == $past(xfer_ecc)); // R4

    AST_ONESHOT_ECC: assert property (@(posedge clk) disable iff (rst)
        ecc_fire && !ctl_rep && !ctrl_wr |=> !ctl_ecc); // R6

    AST_ONESHOT_PAR: assert property (@(posedge clk) disable iff (rst)
        par_fire && !ctl_rep && !ctrl_wr |=> !ctl_par); // R7

    AST_PAR_GATED: assert property (@(posedge clk) disable iff (rst)
        out_par_flip |-> out_valid && $past(ctl_par)); // R7

    AST_REPEAT_KEEP: assert property (@(posedge clk) disable iff (rst)
        ctl_rep && ctl_ecc && !ctrl_wr |=> ctl_ecc); // R8

    AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> ctl_all == $past(reg_wr_data[4:0])); // R10

endmodule

bind ecc_inject_ctrl ecc_inject_chk #(.ECC_W(ECC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .reg_wr_data (reg_wr_data),
    .reg_rd_sel  (reg_rd_sel),
    .reg_rd_data (reg_rd_data),
    .xfer_valid  (xfer_valid),
    .xfer_ecc    (xfer_ecc),
    .out_valid   (out_valid),
    .out_ecc     (out_ecc),
    .out_par_flip(out_par_flip),
    .ecc_fire    (ecc_fire),
    .par_fire    (par_fire),
    .ctl_rep     (ctrl_q.repeat_en),
    .ctl_ecc     (ctrl_q.ecc_arm),
    .ctl_par     (ctrl_q.par_arm),
    .ctl_all     (ctrl_q)
);

// File: tb/ecc_inject_ctrl_test.sv
module ecc_inject_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_sel = '0;
    logic [31:0] reg_rd_data;
    logic        xfer_valid = 1'b0;
    logic [31:0] xfer_addr = '0;
    logic        xfer_upper = 1'b0;
    logic [31:0] xfer_ecc = '0;
    logic        out_valid;
    logic [31:0] out_ecc;
    logic        out_par_flip;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] ecc;
        logic        par;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    ecc_inject_ctrl uut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_upper(xfer_upper),
        .xfer_ecc(xfer_ecc),
        .out_valid(out_valid), .out_ecc(out_ecc), .out_par_flip(out_par_flip)
    );

    // monitor: compares each output beat against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R4 unexpected beat: actual ecc=%h expected none", out_ecc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (out_ecc !== e.ecc || out_par_flip !== e.par) begin
                    failures++;
                    $display("FAIL %s: actual ecc=%h par=%b expected ecc=%h par=%b",
                             e.tag, out_ecc, out_par_flip, e.ecc, e.par);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd_sel = sel;
        #1;
        checks++;
        if (reg_rd_data !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, reg_rd_data, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic up, input logic [31:0] e,
                        input logic [31:0] exp_e, input logic exp_p, input string tag);
        exp_t x;
        x.ecc = exp_e; x.par = exp_p; x.tag = tag;
        @(negedge clk);
        exp_q.push_back(x);
        xfer_valid = 1'b1; xfer_addr = a; xfer_upper = up; xfer_ecc = e;
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    localparam logic [31:0] FM = 32'h0000_00A5;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || out_par_flip !== 1'b0) begin
            failures++;
            $display("FAIL R1 outputs: actual v=%b p=%b expected 0 0", out_valid, out_par_flip);
        end
        for (int s = 0; s < 4; s++) rd_chk(2'(s), 32'h0, "R1 reset reg");

        // R2 reserved bits and layout
        wr(2'd3, 32'hFFFF_FFE0);
        rd_chk(2'd3, 32'h0, "R2 reserved");
        wr(2'd3, 32'h0000_0015);
        rd_chk(2'd3, 32'h0000_0015, "R2 fields");
        wr(2'd3, 32'h0);

        // R4 pass-through when disarmed
        send(32'h0, 1'b0, 32'h1234_5678, 32'h1234_5678, 1'b0, "R4 disarmed");

        // R6 one-shot ECC, zero match mask matches all (R3)
        wr(2'd2, FM);
        wr(2'd3, 32'h08);
        send(32'hDEAD_0000, 1'b1, 32'h1234_5678, 32'h1234_5678 ^ FM, 1'b0, "R3 R6 first beat");
        send(32'hDEAD_0000, 1'b1, 32'h1234_5678, 32'h1234_5678, 1'b0, "R6 second beat");
        rd_chk(2'd3, 32'h0, "R6 arm cleared");

        // R3 R11 masked address compare
        wr(2'd0, 32'h0000_1000);
        wr(2'd1, 32'hFFFF_F000);
        wr(2'd3, 32'h08);
        send(32'h0000_2040, 1'b0, 32'hCAFE_0001, 32'hCAFE_0001, 1'b0, "R11 no match");
        rd_chk(2'd3, 32'h08, "R11 arm kept");
        send(32'h0000_1FFC, 1'b0, 32'hCAFE_0002, 32'hCAFE_0002 ^ FM, 1'b0, "R3 match");

        // R5 half select
        wr(2'd3, 32'h0A);
        send(32'h1000, 1'b1, 32'h0000_0011, 32'h0000_0011, 1'b0, "R5 low-only upper beat");
        send(32'h1000, 1'b0, 32'h0000_0022, 32'h0000_0022 ^ FM, 1'b0, "R5 low-only lower beat");
        wr(2'd3, 32'h0C);
        send(32'h1000, 1'b0, 32'h0000_0033, 32'h0000_0033, 1'b0, "R5 high-only lower beat");
        send(32'h1000, 1'b1, 32'h0000_0044, 32'h0000_0044 ^ FM, 1'b0, "R5 high-only upper beat");
        wr(2'd3, 32'h0E);
        send(32'h1000, 1'b0, 32'h0000_0055, 32'h0000_0055 ^ FM, 1'b0, "R5 both halves");

        // R8 repeat
        wr(2'd3, 32'h19);
        for (int i = 0; i < 3; i++)
            send(32'h1000, i[0], 32'h0F0F_0000 + i, (32'h0F0F_0000 + i) ^ FM, 1'b1, "R8 repeat beat");
        rd_chk(2'd3, 32'h19, "R8 arms held");
        wr(2'd3, 32'h0);
        send(32'h1000, 1'b0, 32'h0F0F_00FF, 32'h0F0F_00FF, 1'b0, "R8 after clear");

        // R7 parity only
        wr(2'd3, 32'h10);
        send(32'h1000, 1'b0, 32'h0000_0077, 32'h0000_0077, 1'b1, "R7 parity only");
        send(32'h1000, 1'b0, 32'h0000_0078, 32'h0000_0078, 1'b0, "R7 parity one-shot");

        // R9 both arms together
        wr(2'd3, 32'h18);
        send(32'h1000, 1'b1, 32'h0000_0088, 32'h0000_0088 ^ FM, 1'b1, "R9 both fire");
        rd_chk(2'd3, 32'h0, "R9 both cleared");

        // R10 write in same cycle as self-clear
        wr(2'd3, 32'h08);
        begin
            exp_t x;
            x.ecc = 32'h0000_0099 ^ FM; x.par = 1'b0; x.tag = "R10 collide beat";
            @(negedge clk);
            exp_q.push_back(x);
            xfer_valid = 1'b1; xfer_addr = 32'h1000; xfer_upper = 1'b0; xfer_ecc = 32'h0000_0099;
            reg_wr_en = 1'b1; reg_wr_sel = 2'd3; reg_wr_data = 32'h08;
            @(negedge clk);
            xfer_valid = 1'b0; reg_wr_en = 1'b0;
        end
        rd_chk(2'd3, 32'h08, "R10 write kept arm");
        send(32'h1000, 1'b0, 32'h0000_00AA, 32'h0000_00AA ^ FM, 1'b0, "R10 next beat");
        send(32'h1000, 1'b0, 32'h0000_00BB, 32'h0000_00BB, 1'b0, "R10 then clear");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R4 missing beats: actual pending=%0d expected 0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule